// File: doc/BRIEF.md
# Multi-Step ADC Sample Sequencer

This block runs a short programmed list of conversions each time a trigger arrives. A list holds up to eight steps. For each step the block drives the converter's input selection and holds a conversion request. It then waits for the converter's done pulse and registers the result, tagged with the step's index, as a push into a result FIFO. The walk stops at the first step marked as the end of the list. If no step is marked, it stops after the last step the instance has, and a configuration-error flag is raised.

Two 32-bit configuration words set the steps. Each word gives one 4-bit nibble to each step: step k owns bits [4k+3:4k]. The select word carries the channel number. The control word carries, per step, a temperature-sensor select, an interrupt enable, an end marker and a differential select. In differential mode the channel field names a pair, and the two pins of that pair are driven as the positive and negative inputs. Interrupt status is sticky and is cleared by writing 1. The controller-level interrupt is the raw status gated by a mask input. A build-time parameter gives a single-step variant, in which the first step always ends the list.

Top module: `adc_step_sequencer`

## Requirements
- R1: After reset both configuration readbacks are zero (except the forced end bit of R11), busy and the request are low, and the raw interrupt, masked interrupt, configuration-error and trigger-overflow flags are all 0.
- R2: The select word keeps only bits [4k+1:4k] of each nibble as the 2-bit channel of step k. Bits [4k+3:4k+2] read back as 0, so writing all ones reads back 0x33333333.
- R3: The control word keeps all 32 bits. Nibble k is, from bit 4k+3 down to 4k: temperature select, interrupt enable, end, differential. A trigger while idle starts at step 0, and steps run in index order. Each done pulse produces a push one cycle later that carries the step index as its tag and the converter data.
- R4: The step whose end bit is set is the last one converted. In the cycle after its push, busy and the request are low, and later steps are never requested, whatever their fields hold.
- R5: A step with the temperature bit set asserts the temperature select, drives positive and negative inputs of 0, and keeps differential low even if its differential bit is set.
- R6: A step with the differential bit set and the temperature bit clear, and channel field i, drives positive input 2i, negative input 2i+1, and differential high. A single-ended step drives positive input equal to the channel and negative input 0.
- R7: A step with the interrupt enable set raises the raw interrupt in the cycle its push appears. Several steps of one list may each raise it. It stays set until a 1 on clear bit 0, and a new event in the same cycle as a clear wins.
- R8: The interrupt output equals the raw interrupt while the mask input is 1, and is 0 while the mask is 0.
- R9: If the last step of the instance completes without its end bit set, the list stops and the configuration-error flag is set. It clears on a 1 on clear bit 2.
- R10: A trigger while a list is running neither restarts nor changes it, and it sets the trigger-overflow flag. The flag clears on a 1 on clear bit 1.
- R11: With NUM_STEPS = 1, control bit 1 (the end bit of step 0) reads 1 whatever is written, and each trigger converts exactly one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mux_we_i | input | 1 | Write strobe for the select word |
| ctl_we_i | input | 1 | Write strobe for the control word |
| cfg_wdata_i | input | 32 | Write data for either word |
| mux_rd_o | output | 32 | Select word readback |
| ctl_rd_o | output | 32 | Control word readback |
| trig_i | input | 1 | Start trigger, one cycle |
| busy_o | output | 1 | A list is running |
| conv_req_o | output | 1 | Conversion request for the current step |
| conv_pos_o | output | 3 | Positive analog input index |
| conv_neg_o | output | 3 | Negative analog input index (differential only) |
| conv_diff_o | output | 1 | Differential conversion |
| conv_temp_o | output | 1 | Convert the temperature sensor |
| conv_done_i | input | 1 | Converter finished the current step |
| conv_data_i | input | RES_W | Conversion result |
| fifo_push_o | output | 1 | Push into the result FIFO |
| fifo_tag_o | output | 3 | Step index of the pushed result |
| fifo_data_o | output | RES_W | Pushed result |
| irq_mask_i | input | 1 | Interrupt mask, 1 passes |
| stat_clr_i | input | 3 | Write-1-to-clear: bit0 raw irq, bit1 overflow, bit2 config error |
| irq_raw_o | output | 1 | Sticky raw interrupt status |
| irq_o | output | 1 | Masked interrupt |
| cfg_err_o | output | 1 | No end marker was found |
| trig_ovf_o | output | 1 | A trigger arrived while busy |

## Verification
The bench builds two instances. The first uses NUM_STEPS = 8. With it the bench can run a full eight-step list that has no end marker, which is the only way to reach the configuration-error path. It also covers ending on a middle step while later steps still hold non-zero fields. The second uses NUM_STEPS = 1, which brings the forced end bit into reach: that instance reads the bit back as 1 and converts one step per trigger even when a write tries to clear the bit. Both instances share the configuration writes, so each write also stimulates the single-step instance.

// File: rtl/adc_seq_pkg.sv
// Shared constants and step decoding for the sample sequencer.
// Assumes at most eight steps and 4-bit nibbles per step in each word.
package adc_seq_pkg;
    localparam int MAX_STEPS = 8;
    localparam int CH_W      = 2;
    localparam int TAG_W     = 3;
    localparam int AIN_W     = CH_W + 1;

    typedef struct packed {
        logic            ts;
        logic            ie;
        logic            last;
        logic            diff;
        logic [CH_W-1:0] ch;
    } step_t;

    // Extract step k's fields from the two configuration words.
    function automatic step_t pick_step(input logic [31:0] sel_w,
                                        input logic [31:0] ctl_w,
                                        input logic [TAG_W-1:0] k);
        step_t s;
        logic [3:0] nib;
        nib    = ctl_w[{k, 2'b00} +: 4];
        s.ts   = nib[3];
        s.ie   = nib[2];
        s.last = nib[1];
        s.diff = nib[0];
        s.ch   = sel_w[{k, 2'b00} +: CH_W];
        return s;
    endfunction
endpackage

// File: rtl/adc_seq_cfg.sv
// Holds the select and control words. Reserved select bits are kept at
// zero. A single-step build forces the step-0 end bit on the readback.
// Assumes writes are single-cycle strobes.
module adc_seq_cfg #(
    parameter int NUM_STEPS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mux_we_i,
    input  logic        ctl_we_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] mux_o,
    output logic [31:0] ctl_o
);
    import adc_seq_pkg::*;

    localparam logic [3:0]  NIB_KEEP = 4'((1 << CH_W) - 1);
    localparam logic [31:0] MUX_KEEP = {MAX_STEPS{NIB_KEEP}};

    logic [31:0] mux_q;
    logic [31:0] ctl_q;

    // Configuration storage, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mux_q <= '0;
            ctl_q <= '0;
        end else begin
            if (mux_we_i) mux_q <= wdata_i & MUX_KEEP;
            if (ctl_we_i) ctl_q <= wdata_i;
        end
    end

    assign mux_o = mux_q;

    generate
        if (NUM_STEPS == 1) begin : g_single
            assign ctl_o = ctl_q | 32'h0000_0002;
        end else begin : g_multi
            assign ctl_o = ctl_q;
        end
    endgenerate
endmodule

// File: rtl/adc_seq_walker.sv
// Walks the step list: holds the request, decodes the step's input
// selection, registers one push per done pulse, and emits event pulses
// for the status block. Assumes done only arrives while requested.
module adc_seq_walker #(
    parameter int NUM_STEPS = 8,
    parameter int RES_W     = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          trig_i,
    input  logic [31:0]                   mux_i,
    input  logic [31:0]                   ctl_i,
    input  logic                          conv_done_i,
    input  logic [RES_W-1:0]              conv_data_i,
    output logic                          busy_o,
    output logic                          conv_req_o,
    output logic [adc_seq_pkg::AIN_W-1:0] conv_pos_o,
    output logic [adc_seq_pkg::AIN_W-1:0] conv_neg_o,
    output logic                          conv_diff_o,
    output logic                          conv_temp_o,
    output logic                          push_o,
    output logic [adc_seq_pkg::TAG_W-1:0] push_tag_o,
    output logic [RES_W-1:0]              push_data_o,
    output logic                          irq_evt_o,
    output logic                          err_evt_o,
    output logic                          ovf_evt_o
);
    import adc_seq_pkg::*;

    localparam logic [TAG_W-1:0] LAST_IDX = TAG_W'(NUM_STEPS - 1);

    logic             busy_q;
    logic [TAG_W-1:0] step_q;
    step_t            cur;
    logic             done_ok;
    logic             finish;

    // Decode the current step and its stop condition.
    always_comb begin
        cur     = pick_step(mux_i, ctl_i, step_q);
        done_ok = busy_q && conv_done_i;
        finish  = cur.last || (step_q == LAST_IDX);
    end

    // Sequencing state and the registered FIFO push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q      <= 1'b0;
            step_q      <= '0;
            push_o      <= 1'b0;
            push_tag_o  <= '0;
            push_data_o <= '0;
        end else begin
            push_o <= done_ok;
            if (done_ok) begin
                push_tag_o  <= step_q;
                push_data_o <= conv_data_i;
            end
            if (!busy_q && trig_i) begin
                busy_q <= 1'b1;
                step_q <= '0;
            end else if (done_ok) begin
                if (finish) busy_q <= 1'b0;
                else        step_q <= step_q + 1'b1;
            end
        end
    end

    // Converter input selection for the current step.
    always_comb begin
        conv_req_o  = busy_q;
        conv_temp_o = busy_q && cur.ts;
        conv_diff_o = busy_q && cur.diff && !cur.ts;
        conv_pos_o  = '0;
        conv_neg_o  = '0;
        if (!cur.ts) begin
            if (cur.diff) begin
                conv_pos_o = {cur.ch, 1'b0};
                conv_neg_o = {cur.ch, 1'b1};
            end else begin
                conv_pos_o = {1'b0, cur.ch};
            end
        end
    end

    assign busy_o    = busy_q;
    assign irq_evt_o = done_ok && cur.ie;
    assign err_evt_o = done_ok && (step_q == LAST_IDX) && !cur.last;
    assign ovf_evt_o = busy_q && trig_i;

    // R3
    push_follows_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_ok |=> (push_o && push_tag_o == $past(step_q)));

    // R4
    stop_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok && cur.last) |=> !conv_req_o);

    // R5
    temp_not_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_temp_o |-> (!conv_diff_o && conv_pos_o == '0));
endmodule

// File: rtl/adc_seq_status.sv
// Sticky status flags with write-1-to-clear. A set in the same cycle as
// a clear wins. Also applies the interrupt mask.
// Assumes event inputs are single-cycle pulses.
module adc_seq_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_evt_i,
    input  logic       err_evt_i,
    input  logic       ovf_evt_i,
    input  logic [2:0] clr_i,
    input  logic       mask_i,
    output logic       irq_raw_o,
    output logic       irq_o,
    output logic       err_o,
    output logic       ovf_o
);
    logic raw_q, err_q, ovf_q;

    // Sticky flags: a set has priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
            err_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            raw_q <= irq_evt_i | (raw_q & ~clr_i[0]);
            ovf_q <= ovf_evt_i | (ovf_q & ~clr_i[1]);
            err_q <= err_evt_i | (err_q & ~clr_i[2]);
        end
    end

    assign irq_raw_o = raw_q;
    assign irq_o     = raw_q & mask_i;
    assign err_o     = err_q;
    assign ovf_o     = ovf_q;

    // R7
    raw_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(raw_q) |-> $past(clr_i[0]));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_q) |-> $past(clr_i[2]));
endmodule

// File: rtl/adc_step_sequencer.sv
// Top of the multi-step sample sequencer: configuration words, step
// walker and sticky status. NUM_STEPS of 1 gives the single-step variant.
// Assumes NUM_STEPS is between 1 and 8.
module adc_step_sequencer #(
    parameter int NUM_STEPS = 8,
    parameter int RES_W     = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mux_we_i,
    input  logic             ctl_we_i,
    input  logic [31:0]      cfg_wdata_i,
    output logic [31:0]      mux_rd_o,
    output logic [31:0]      ctl_rd_o,
    input  logic             trig_i,
    output logic             busy_o,
    output logic             conv_req_o,
    output logic [2:0]       conv_pos_o,
    output logic [2:0]       conv_neg_o,
    output logic             conv_diff_o,
    output logic             conv_temp_o,
    input  logic             conv_done_i,
    input  logic [RES_W-1:0] conv_data_i,
    output logic             fifo_push_o,
    output logic [2:0]       fifo_tag_o,
    output logic [RES_W-1:0] fifo_data_o,
    input  logic             irq_mask_i,
    input  logic [2:0]       stat_clr_i,
    output logic             irq_raw_o,
    output logic             irq_o,
    output logic             cfg_err_o,
    output logic             trig_ovf_o
);
    logic irq_evt, err_evt, ovf_evt;

    adc_seq_cfg #(.NUM_STEPS(NUM_STEPS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .mux_we_i(mux_we_i), .ctl_we_i(ctl_we_i),
        .wdata_i(cfg_wdata_i), .mux_o(mux_rd_o), .ctl_o(ctl_rd_o)
    );

    adc_seq_walker #(.NUM_STEPS(NUM_STEPS), .RES_W(RES_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .mux_i(mux_rd_o),
        .ctl_i(ctl_rd_o), .conv_done_i(conv_done_i), .conv_data_i(conv_data_i),
        .busy_o(busy_o), .conv_req_o(conv_req_o), .conv_pos_o(conv_pos_o),
        .conv_neg_o(conv_neg_o), .conv_diff_o(conv_diff_o),
        .conv_temp_o(conv_temp_o), .push_o(fifo_push_o),
        .push_tag_o(fifo_tag_o), .push_data_o(fifo_data_o),
        .irq_evt_o(irq_evt), .err_evt_o(err_evt), .ovf_evt_o(ovf_evt)
    );

    adc_seq_status u_stat (
        .clk(clk), .rst_n(rst_n), .irq_evt_i(irq_evt), .err_evt_i(err_evt),
        .ovf_evt_i(ovf_evt), .clr_i(stat_clr_i), .mask_i(irq_mask_i),
        .irq_raw_o(irq_raw_o), .irq_o(irq_o), .err_o(cfg_err_o),
        .ovf_o(trig_ovf_o)
    );

    // R10
    trig_busy_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && busy_o) |=> trig_ovf_o);
endmodule

// File: tb/test_adc_step_sequencer.sv
module test_adc_step_sequencer;
    localparam int RES_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mux_we = 1'b0, ctl_we = 1'b0;
    logic [31:0] wdata = '0;
    logic trig = 1'b0, trig1 = 1'b0;
    logic done = 1'b0, done1 = 1'b0;
    logic [RES_W-1:0] cdata = '0;
    logic mask = 1'b0;
    logic [2:0] clr = '0;

    logic [31:0] mux_rd, ctl_rd, mux_rd1, ctl_rd1;
    logic busy, req, diff, temp, push, raw, irq, err, ovf;
    logic [2:0] pos, neg, tag;
    logic [RES_W-1:0] fdata;
    logic busy1, req1, diff1, temp1, push1, raw1, irq1, err1, ovf1;
    logic [2:0] pos1, neg1, tag1;
    logic [RES_W-1:0] fdata1;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    adc_step_sequencer #(.NUM_STEPS(8), .RES_W(RES_W)) i_adc_step_sequencer (
        .clk(clk), .rst_n(rst_n), .mux_we_i(mux_we), .ctl_we_i(ctl_we),
        .cfg_wdata_i(wdata), .mux_rd_o(mux_rd), .ctl_rd_o(ctl_rd),
        .trig_i(trig), .busy_o(busy), .conv_req_o(req), .conv_pos_o(pos),
        .conv_neg_o(neg), .conv_diff_o(diff), .conv_temp_o(temp),
        .conv_done_i(done), .conv_data_i(cdata), .fifo_push_o(push),
        .fifo_tag_o(tag), .fifo_data_o(fdata), .irq_mask_i(mask),
        .stat_clr_i(clr), .irq_raw_o(raw), .irq_o(irq), .cfg_err_o(err),
        .trig_ovf_o(ovf)
    );

    adc_step_sequencer #(.NUM_STEPS(1), .RES_W(RES_W)) i_adc_step_sequencer_one (
        .clk(clk), .rst_n(rst_n), .mux_we_i(mux_we), .ctl_we_i(ctl_we),
        .cfg_wdata_i(wdata), .mux_rd_o(mux_rd1), .ctl_rd_o(ctl_rd1),
        .trig_i(trig1), .busy_o(busy1), .conv_req_o(req1), .conv_pos_o(pos1),
        .conv_neg_o(neg1), .conv_diff_o(diff1), .conv_temp_o(temp1),
        .conv_done_i(done1), .conv_data_i(cdata), .fifo_push_o(push1),
        .fifo_tag_o(tag1), .fifo_data_o(fdata1), .irq_mask_i(mask),
        .stat_clr_i(clr), .irq_raw_o(raw1), .irq_o(irq1), .cfg_err_o(err1),
        .trig_ovf_o(ovf1)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    task automatic wr(input bit to_ctl, input logic [31:0] v);
        @(negedge clk);
        wdata = v;
        mux_we = !to_ctl;
        ctl_we = to_ctl;
        @(negedge clk);
        mux_we = 1'b0;
        ctl_we = 1'b0;
    endtask

    task automatic fire();
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic pulse_clr(input logic [2:0] b);
        clr = b;
        @(negedge clk);
        clr = '0;
    endtask

    // Serve one step of the 8-step instance; we are at a negedge.
    task automatic serve(input string r, input logic [2:0] exp_tag,
                         input logic [RES_W-1:0] d, input logic [2:0] ep,
                         input logic [2:0] en, input logic ed, input logic et);
        chk({r, " req"}, {31'b0, req}, 1);
        chk({r, " sel"}, {24'b0, pos, neg, ed, et},
            {24'b0, ep, en, ed, et});
        chk({r, " diff/temp"}, {30'b0, diff, temp}, {30'b0, ed, et});
        done = 1'b1;
        cdata = d;
        @(negedge clk);
        done = 1'b0;
        chk({r, " push"}, {31'b0, push}, 1);
        chk({r, " tag"}, {29'b0, tag}, {29'b0, exp_tag});
        chk({r, " data"}, {20'b0, fdata}, {20'b0, d});
    endtask

    task automatic t_reset();
        chk("R1 mux_rd", mux_rd, 0);
        chk("R1 ctl_rd", ctl_rd, 0);
        chk("R1 busy/req", {30'b0, busy, req}, 0);
        chk("R1 flags", {28'b0, raw, irq, err, ovf}, 0);
        chk("R11 single ctl_rd reset", ctl_rd1, 32'h2);
    endtask

    task automatic t_readback();
        wr(1'b0, 32'hFFFF_FFFF);
        chk("R2 reserved select bits", mux_rd, 32'h3333_3333);
        wr(1'b1, 32'hA5A5_5A5A);
        chk("R3 control readback", ctl_rd, 32'hA5A5_5A5A);
        wr(1'b1, 32'h0000_0000);
        chk("R11 forced end bit", ctl_rd1, 32'h2);
    endtask

    task automatic t_sequence();
        wr(1'b0, 32'h0000_0312);
        wr(1'b1, 32'h0000_4A10);
        fire();
        chk("R3 busy after trigger", {31'b0, busy}, 1);
        serve("R6 single-ended", 3'd0, 12'h111, 3'd2, 3'd0, 1'b0, 1'b0);
        serve("R6 diff pair", 3'd1, 12'h222, 3'd2, 3'd3, 1'b1, 1'b0);
        serve("R5 temp", 3'd2, 12'h333, 3'd0, 3'd0, 1'b0, 1'b1);
        chk("R4 busy low after end", {31'b0, busy}, 0);
        @(negedge clk);
        chk("R4 no later request", {30'b0, req, push}, 0);
        chk("R4 later IE step never ran", {31'b0, raw}, 0);
        chk("R9 no error when end set", {31'b0, err}, 0);
    endtask

    task automatic t_irq();
        wr(1'b0, 32'h0);
        wr(1'b1, 32'h0000_0064);
        mask = 1'b0;
        fire();
        serve("R7 step0", 3'd0, 12'h0AA, 3'd0, 3'd0, 1'b0, 1'b0);
        chk("R7 raw set", {31'b0, raw}, 1);
        chk("R8 masked off", {31'b0, irq}, 0);
        mask = 1'b1;
        #1;
        chk("R8 mask on", {31'b0, irq}, 1);
        pulse_clr(3'b001);
        chk("R7 cleared", {30'b0, raw, irq}, 0);
        serve("R7 step1", 3'd1, 12'h0BB, 3'd0, 3'd0, 1'b0, 1'b0);
        chk("R7 second step raises", {30'b0, raw, irq}, 2'b11);
        @(negedge clk);
        chk("R7 sticky", {31'b0, raw}, 1);
        pulse_clr(3'b001);
        chk("R7 clear again", {31'b0, raw}, 0);
        mask = 1'b0;
    endtask

    task automatic t_noend();
        wr(1'b1, 32'h0);
        fire();
        for (int k = 0; k < 8; k++)
            serve("R9 walk", 3'(k), 12'(k + 5), 3'd0, 3'd0, 1'b0, 1'b0);
        chk("R9 stopped", {31'b0, busy}, 0);
        chk("R9 error set", {31'b0, err}, 1);
        pulse_clr(3'b100);
        chk("R9 error cleared", {31'b0, err}, 0);
    endtask

    task automatic t_ovf();
        wr(1'b1, 32'h0000_0020);
        fire();
        serve("R10 step0", 3'd0, 12'h010, 3'd0, 3'd0, 1'b0, 1'b0);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        chk("R10 overflow set", {31'b0, ovf}, 1);
        serve("R10 not restarted", 3'd1, 12'h020, 3'd0, 3'd0, 1'b0, 1'b0);
        chk("R10 ended normally", {31'b0, busy}, 0);
        pulse_clr(3'b010);
        chk("R10 overflow cleared", {31'b0, ovf}, 0);
    endtask

    task automatic t_single();
        wr(1'b1, 32'h0);
        @(negedge clk);
        trig1 = 1'b1;
        @(negedge clk);
        trig1 = 1'b0;
        chk("R11 busy", {31'b0, req1}, 1);
        done1 = 1'b1;
        cdata = 12'h5A5;
        @(negedge clk);
        done1 = 1'b0;
        chk("R11 push", {28'b0, push1, tag1}, {28'b0, 1'b1, 3'd0});
        chk("R11 one step only", {30'b0, busy1, err1}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_sequence();
        t_irq();
        t_noend();
        t_ovf();
        t_single();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule